// File: doc/BRIEF.md
# Receive Address Filter and Length Shaper

This block sits on the receive path of a 10/100 Ethernet MAC, after the line decoder and before the buffer writer. It takes one frame at a time as a byte stream, holds the six destination bytes until they are complete, and then decides whether the frame is kept. The destination is classed as broadcast (all ones), as hashed (group bit set, or hash-all mode on) or as unicast. A hashed destination is looked up in a 64-bit table, and a unicast destination is compared with the station address. A frame that misses is dropped unless promiscuous mode is on; in that case it is kept and marked with a miss flag.

A kept frame leaves the block as a byte stream, delayed by six bytes, that is reshaped in length. The stream is cut at a copy limit, and a short frame can be zero-filled up to the minimum length. Four zero bytes stand in for the frame check sequence, and they are shortened or left out under the pad and cut rules. When the frame is done, a one-cycle status beat reports whether the frame was kept, its final length and the descriptor flags. The block does not check any CRC.

The block reads its configuration live from its inputs: the mode word, a packed min/max length word, two hash words and two station-address words. Software is expected to hold them still while a frame is in flight.

Top module: `rx_addr_shaper`

## Requirements
- R1: Address classification is made only for frames of 6 or more bytes. A frame with fewer than 6 bytes counts as a miss.
- R2: A destination of six 0xFF bytes is broadcast. It is a miss exactly when mode bit 3 (broadcast reject) is set.
- R3: If destination byte 0 has bit 0 set, or mode bit 4 (hash-all) is set, the hash index is bits 31:26 of a CRC-32 over the six destination bytes. The CRC uses polynomial 0x04C11DB7, a shift-left register preset to all ones, bits taken LSB first, and no final inversion. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 select the bit within that word. A clear bit is a miss.
- R4: Any other destination is unicast. It hits when bytes 0 and 1 equal `sta_hi[15:8]` and `sta_hi[7:0]`, and bytes 2 to 5 equal `sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R5: A miss with mode bit 5 (promiscuous) clear drops the frame: no output bytes, and a status beat with `stat_accept`=0, length 0 and all flags 0. A miss with bit 5 set keeps the frame and sets `stat_flags[7]`.
- R6: The copy limit L is 65536 when mode bit 14 (huge) is set, and `pkt_len[15:0]` (max length) otherwise. Only the first min(size, L) input bytes are passed. A frame of size >= L gets no FCS bytes.
- R7: `stat_flags[3]` (too long) is set for a kept frame exactly when mode bit 14 is set and the size exceeds `pkt_len[15:0]`.
- R8: Let copy = min(size, L) and F = 4 when size < L, otherwise 0. The output is copy data bytes followed by zeros, up to a total of copy+F. When mode bit 15 (pad) is set, the total is max(`pkt_len[31:16]`, copy+F). All other `stat_flags` bits are always 0.
- R9: `stat_len` equals the number of bytes output for the frame, and `out_last` marks only the final output byte. The status beat comes after the last byte. Output byte k of a frame is input byte k.
- R10: After reset, `out_valid` and `stat_valid` are low until a frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the frame |
| mode | input | 16 | Mode word: bit 3 broadcast reject, 4 hash-all, 5 promiscuous, 14 huge, 15 pad |
| pkt_len | input | 32 | Min length in 31:16, max length in 15:0 |
| hash_lo | input | 32 | Hash table bits 0 to 31 |
| hash_hi | input | 32 | Hash table bits 32 to 63 |
| sta_lo | input | 32 | Station address bytes 2 to 5 |
| sta_hi | input | 32 | Station address bytes 0 and 1 in bits 15:0 |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of a frame |
| stat_valid | output | 1 | One-cycle status beat per frame |
| stat_accept | output | 1 | Frame was kept |
| stat_len | output | CW | Final length in bytes |
| stat_flags | output | 9 | Descriptor flags: bit 7 miss, bit 3 too long |

## Verification
The assertions assume three things about the inputs. Bytes of a frame arrive in a contiguous run of `in_valid` ending with `in_last`. No new byte arrives between the end of a frame and its status beat. The min length is no larger than the max length, and the configuration stays constant within a frame. The bench drives each frame back to back, then idles until it sees the status beat. It changes the configuration only between frames, and its sweeps keep the min at or below the max. The sweeps cover every combination of pad, huge, promiscuous and broadcast reject, over five destination kinds. Frame sizes are chosen to straddle 6, the minimum, the maximum and the FCS band just below the minimum.

// File: rtl/rx_addr_shaper.sv
module rx_addr_shaper #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [15:0]   mode,
  input  logic [31:0]   pkt_len,
  input  logic [31:0]   hash_lo,
  input  logic [31:0]   hash_hi,
  input  logic [31:0]   sta_lo,
  input  logic [31:0]   sta_hi,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          stat_valid,
  output logic          stat_accept,
  output logic [CW-1:0] stat_len,
  output logic [8:0]    stat_flags
);
  localparam int DA = 6;
  localparam logic [CW-1:0] HUGE_LIM = CW'(65536);
  localparam logic [CW-1:0] FCS_N = CW'(4);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ b[i]) ? 32'h04C1_1DB7 : 32'h0);
    return r;
  endfunction

  logic [CW-1:0] cnt, oidx;
  logic          tail;
  logic [7:0]    dl [DA];
  logic [7:0]    da [DA];
  logic [31:0]   crc;

  wire [CW-1:0] minfl = CW'(pkt_len[31:16]);
  wire [CW-1:0] maxfl = CW'(pkt_len[15:0]);
  wire [CW-1:0] lim   = mode[14] ? HUGE_LIM : maxfl;
  wire          short_f = cnt < CW'(DA);

  wire       bcast = (da[0] & da[1] & da[2] & da[3] & da[4] & da[5]) == 8'hFF;
  wire       hashed = da[0][0] | mode[4];
  wire [5:0] hidx = crc[31:26];
  wire       hbit = hidx[5] ? hash_hi[hidx[4:0]] : hash_lo[hidx[4:0]];
  wire       uhit = {da[0], da[1]} == sta_hi[15:0] &&
                    {da[2], da[3], da[4], da[5]} == sta_lo;
  wire       miss = short_f | (bcast ? mode[3] : hashed ? !hbit : !uhit);
  wire       accept = !miss | mode[5];

  wire           under = cnt < lim;
  wire [CW-1:0]  copy  = under ? cnt : lim;
  wire [CW-1:0]  sum   = copy + (under ? FCS_N : '0);
  wire [CW-1:0]  total = (mode[15] && sum < minfl) ? minfl : sum;

  wire [CW-1:0] rx_k    = cnt - CW'(DA);
  wire          rx_emit = in_valid && !tail && !short_f && accept && rx_k < lim;
  wire [CW-1:0] back    = cnt - CW'(1) - oidx;
  wire [CW-1:0] cnt_inc = (&cnt) ? cnt : cnt + CW'(1);
  wire          fin     = !accept || oidx >= total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; oidx <= '0; tail <= 1'b0; crc <= '1;
      for (int i = 0; i < DA; i++) begin dl[i] <= '0; da[i] <= '0; end
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      stat_valid <= 1'b0; stat_accept <= 1'b0; stat_len <= '0; stat_flags <= '0;
    end else begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      stat_valid <= 1'b0;
      if (!tail) begin
        if (in_valid) begin
          dl[0] <= in_data;
          for (int i = 1; i < DA; i++) dl[i] <= dl[i-1];
          if (short_f) begin
            da[cnt[2:0]] <= in_data;
            crc <= crc_byte(crc, in_data);
          end
          out_valid <= rx_emit;
          out_data  <= dl[DA-1];
          out_last  <= rx_emit && (rx_k == lim - CW'(1));
          cnt <= cnt_inc;
          if (in_last) begin
            tail <= 1'b1;
            oidx <= (cnt_inc >= CW'(DA)) ? cnt_inc - CW'(DA) : '0;
          end
        end
      end else if (fin) begin
        stat_valid  <= 1'b1;
        stat_accept <= accept;
        stat_len    <= accept ? total : '0;
        stat_flags  <= '0;
        stat_flags[7] <= accept & miss;
        stat_flags[3] <= accept & mode[14] & (cnt > maxfl);
        tail <= 1'b0;
        cnt  <= '0;
        crc  <= '1;
      end else begin
        out_valid <= 1'b1;
        out_data  <= (oidx < copy) ? dl[back[2:0]] : 8'h00;
        out_last  <= oidx == total - CW'(1);
        oidx <= oidx + CW'(1);
      end
    end
  end

  logic [CW-1:0] ob_cnt;
  logic          seen_last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_cnt <= '0; seen_last <= 1'b0;
    end else if (stat_valid) begin
      ob_cnt <= '0; seen_last <= 1'b0;
    end else if (out_valid) begin
      ob_cnt <= ob_cnt + CW'(1);
      seen_last <= out_last;
    end
  end

  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ob_cnt == stat_len); // R9
  AST_LAST_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_len != '0) |-> seen_last); // R9
  AST_NO_BYTE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !seen_last); // R9
  AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_accept) |-> (stat_len == '0 && stat_flags == '0)); // R5
  AST_PAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_accept && mode[15]) |-> stat_len >= minfl); // R8
  AST_TOOLONG_HUGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_flags[3]) |-> mode[14]); // R7
  AST_SHORT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_accept && cnt == '0 && $past(cnt) < CW'(DA)) |-> stat_flags[7]); // R1
endmodule

// File: tb/rx_addr_shaper_tb.sv
module rx_addr_shaper_tb_top;
  localparam int CW = 18;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_last;
  logic [7:0] in_data;
  logic [15:0] mode;
  logic [31:0] pkt_len, hash_lo, hash_hi, sta_lo, sta_hi;
  logic out_valid, out_last, stat_valid, stat_accept;
  logic [7:0] out_data;
  logic [CW-1:0] stat_len;
  logic [8:0] stat_flags;

  rx_addr_shaper #(.CW(CW)) dut_i (.*);

  int total_n = 0, bad_n = 0, cyc = 0;
  logic [7:0] fr [256];
  logic [7:0] got [256];
  logic       gotl [256];
  int gcnt = 0;
  logic seen = 1'b0, s_acc = 1'b0;
  int s_len = 0;
  logic [8:0] s_fl = '0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_valid && gcnt < 256) begin
      got[gcnt] = out_data; gotl[gcnt] = out_last; gcnt++;
    end
    if (rst_n && stat_valid) begin
      seen = 1'b1; s_acc = stat_accept; s_len = int'(stat_len); s_fl = stat_flags;
    end
    if (cyc > 190000) begin
      total_n++; bad_n++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  function automatic logic [31:0] ref_crc(input logic [7:0] d [256]);
    logic [31:0] c = '1;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[31] ^ d[b][i];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic run_frame(input int kind, input int size, input logic [15:0] md, input logic [31:0] pl);
    bit m, acc, under, hs;
    int lim, cpy, tot, minfl, maxfl;
    logic [5:0] hx;
    string rq;
    for (int i = 0; i < size; i++) fr[i] = 8'(i * 13 + size + 1);
    case (kind)
      0: for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
      1: begin fr[0] = 8'((size << 1) | 1); fr[1] = 8'h5E; end
      2: begin fr[0]=8'h02; fr[1]=8'hA4; fr[2]=8'h1B; fr[3]=8'h3C; fr[4]=8'h5D; fr[5]=8'h7E; end
      3: begin fr[0]=8'h02; fr[1]=8'hA4; fr[2]=8'h1B; fr[3]=8'h3C; fr[4]=8'h5D; fr[5]=8'h7E ^ 8'((size << 1) | 1); end
      default: fr[0] = 8'h02;
    endcase
    if (kind == 4) md[4] = 1'b1;
    mode = md; pkt_len = pl;
    minfl = int'(pl[31:16]); maxfl = int'(pl[15:0]);
    rq = (kind == 0) ? "R2" : (kind == 2 || kind == 3) ? "R4" : "R3";
    if (size < 6) begin m = 1; rq = "R1"; end
    else if (fr[0]==8'hFF && fr[1]==8'hFF && fr[2]==8'hFF && fr[3]==8'hFF && fr[4]==8'hFF && fr[5]==8'hFF)
      m = md[3];
    else if (fr[0][0] || md[4]) begin
      hx = ref_crc(fr)[31:26];
      hs = hx[5] ? hash_hi[hx[4:0]] : hash_lo[hx[4:0]];
      m = !hs;
    end else
      m = !(fr[0]==sta_hi[15:8] && fr[1]==sta_hi[7:0] && fr[2]==sta_lo[31:24] &&
            fr[3]==sta_lo[23:16] && fr[4]==sta_lo[15:8] && fr[5]==sta_lo[7:0]);
    acc = !m || md[5];
    lim = md[14] ? 65536 : maxfl;
    under = size < lim;
    cpy = under ? size : lim;
    tot = cpy + (under ? 4 : 0);
    if (md[15] && tot < minfl) tot = minfl;
    if (!acc) tot = 0;

    @(negedge clk);
    gcnt = 0; seen = 1'b0;
    for (int i = 0; i < size; i++) begin
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == size - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    for (int w = 0; w < 400 && !seen; w++) @(negedge clk);
    @(negedge clk);

    chk(seen, "R9", "status beat seen", int'(seen), 1);
    chk(s_acc == acc, rq, "accept (R5 drop rule)", int'(s_acc), int'(acc));
    chk(s_len == tot, under ? "R8" : "R6", "final length", s_len, tot);
    chk(gcnt == tot, "R9", "output byte count", gcnt, tot);
    chk(s_fl[7] == (acc && m), "R5", "miss flag", int'(s_fl[7]), int'(acc && m));
    chk(s_fl[3] == (acc && md[14] && size > maxfl), "R7", "too-long flag",
        int'(s_fl[3]), int'(acc && md[14] && size > maxfl));
    chk((s_fl & 9'h177) == 0, "R8", "other flags clear", int'(s_fl), 0);
    for (int k = 0; k < gcnt && k < tot; k++) begin
      logic [7:0] e = (k < cpy) ? fr[k] : 8'h00;
      if (got[k] !== e) chk(0, (k < cpy) ? "R9" : "R8", "byte value", int'(got[k]), int'(e));
      if (gotl[k] !== (k == tot - 1)) chk(0, "R9", "last marker", int'(gotl[k]), int'(k == tot - 1));
    end
    total_n++;
  endtask

  initial begin
    int sizes [14] = '{1, 5, 6, 7, 15, 16, 17, 19, 20, 21, 39, 40, 41, 50};
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    mode = '0; pkt_len = {16'd20, 16'd40};
    hash_lo = 32'hA5A5_0F0F; hash_hi = 32'h3C3C_F00F;
    sta_hi = 32'h0000_02A4; sta_lo = 32'h1B3C_5D7E;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && stat_valid == 0, "R10", "idle in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && stat_valid == 0, "R10", "idle after reset", int'(stat_valid), 0);
    for (int cfg = 0; cfg < 16; cfg++)
      for (int kind = 0; kind < 5; kind++)
        for (int s = 0; s < 14; s++) begin
          logic [15:0] md = '0;
          md[15] = cfg[0]; md[14] = cfg[1]; md[5] = cfg[2]; md[3] = cfg[3];
          run_frame(kind, sizes[s], md, {16'd20, 16'd40});
        end
    for (int kind = 0; kind < 5; kind++)
      for (int s = 58; s < 66; s++)
        run_frame(kind, s, 16'h8020, 32'h0040_0600);
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule